// File: doc/BRIEF.md
# Selectable Lane Test Pattern Generator

This block drives one serial bit per clock toward a transmit lane, together with a valid flag. A 2-bit mode field, the two least significant bits of an 8-bit control word written by software, picks the source of that bit. The source is either the normal data path, a pseudo-random binary sequence of period 127, a slow square wave with a run length of five bits, or a fast alternating pattern. The other six bits of the control word belong to neighbouring fields, and this block takes no action on them.

Every source goes through the same output register, so the serial bit arrives one cycle after the choice is made, whatever the mode. The two toggle modes are kept apart by a guard. A request to go straight from the fast pattern to the slow pattern is refused. The fast pattern keeps running, and a sticky flag records the refused request. Software must select normal mode before it selects the slow pattern. The block assumes that its clock runs whenever a pattern mode is selected.

Top module: `lane_pattern_gen`

## Requirements
- R1: When `ctrl_wr` is high, `mode_o` takes the value of `ctrl_wdata[1:0]` at the next clock edge. Code 0 is normal, 1 is PRBS7, 2 is the slow toggle and 3 is the fast toggle. `ctrl_wdata[7:2]` has no effect, and `mode_o` holds its value while `ctrl_wr` is low.
- R2: In mode 0, `ser_out` and `ser_valid` equal `data_in` and `data_valid_in` from one cycle earlier.
- R3: In mode 1, the stream comes from the polynomial x^7 + x^6 + 1, seeded with all ones. The first seven bits after entry are 1. After that, bit n+7 equals bit n XOR bit n+1, and the stream repeats every 127 bits. Every entry into mode 1 restarts the stream from the seed.
- R4: In modes 1, 2 and 3, `ser_valid` is 1 from the first pattern bit onward, whatever the value of `data_valid_in`.
- R5: In mode 2, the stream repeats 0000011111 and starts at its first 0 on entry.
- R6: In mode 3, the stream alternates 1,0,1,0 and starts with 1 on entry.
- R7: A write of code 2 while `mode_o` is 3 is refused. `mode_o` stays 3, the fast pattern keeps alternating, and `illegal_seen` becomes 1 and stays 1 until reset. Writing 0 and then 2 enters mode 2 normally.
- R8: While `rst_n` is low at a clock edge, `mode_o`, `illegal_seen`, `ser_out` and `ser_valid` all go to 0, and every pattern restarts on its next entry.
- R9: Writing the mode that is already active does not restart its pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pattern clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 8 | Control word; bits 1:0 hold the mode |
| data_in | input | 1 | Serial bit from the normal data path |
| data_valid_in | input | 1 | Valid flag of the normal data path |
| ser_out | output | 1 | Serial bit sent to the lane |
| ser_valid | output | 1 | Valid flag for `ser_out` |
| mode_o | output | 2 | Mode currently in force |
| illegal_seen | output | 1 | Sticky flag for a refused fast-to-slow switch |

## Verification
The bound checker covers the behaviours that relate one cycle to the next. These are:
- the one-cycle pass-through in normal mode,
- the forced valid flag in the pattern modes,
- the alternation of the fast pattern,
- the refusal of a fast-to-slow request and the stickiness of its flag,
- the mode holding without a write,
- the reset values.

Other behaviours span a whole sequence, so only the bench scenarios can show them. These are the PRBS7 recurrence and its period of 127, the ten-bit shape of the slow toggle, the restart of each pattern on entry, and the continuation of a pattern when its own mode is written again.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_NORMAL  = 2'd0,
      MODE_PRBS    = 2'd1,
      MODE_LOWTOG  = 2'd2,
      MODE_HIGHTOG = 2'd3
   } lpg_mode_e;
endpackage

// File: rtl/lpg_mode_ctrl.sv
module lpg_mode_ctrl
   import lpg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_mode,
   output lpg_mode_e         mode_q,
   output logic              illegal_q
);
   lpg_mode_e req;
   logic      blocked;

   assign req     = lpg_mode_e'(wr_mode);
   // A direct step from the fast toggle to the slow toggle is refused
   assign blocked = (req == MODE_LOWTOG) && (mode_q == MODE_HIGHTOG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= MODE_NORMAL;
         illegal_q <= 1'b0;
      end else if (wr_en) begin
         if (blocked) illegal_q <= 1'b1;
         else         mode_q    <= req;
      end
   end
endmodule

// File: rtl/lpg_prbs.sv
module lpg_prbs #(
   parameter int              LEN  = 7,
   parameter int              TAP  = 6,
   parameter logic [LEN-1:0]  SEED = '1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic bit_o
);
   generate
      if (LEN < 3)                 begin : g_bad_len  $error("lpg_prbs: LEN must be at least 3"); end
      if (TAP < 1 || TAP >= LEN)   begin : g_bad_tap  $error("lpg_prbs: TAP must lie in 1..LEN-1"); end
      if (SEED == '0)              begin : g_bad_seed $error("lpg_prbs: SEED must be nonzero"); end
   endgenerate

   logic [LEN-1:0] st;
   logic           fb;

   assign fb    = st[LEN-1] ^ st[TAP-1];
   assign bit_o = st[LEN-1];

   always_ff @(posedge clk) begin
      if (!rst_n || !run)   st <= SEED;
      else if (st == '0)    st <= SEED;
      else                  st <= {st[LEN-2:0], fb};
   end
endmodule

// File: rtl/lpg_toggle.sv
module lpg_toggle #(
   parameter int   HALF      = 5,
   parameter logic START_BIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic bit_o
);
   generate
      if (HALF < 1) begin : g_bad_half
         $error("lpg_toggle: HALF must be at least 1");
      end else if (HALF == 1) begin : g_phase
         logic phase;
         always_ff @(posedge clk) begin
            if (!rst_n || !run) phase <= START_BIT;
            else                phase <= ~phase;
         end
         assign bit_o = phase;
      end else begin : g_count
         localparam int CW = $clog2(2 * HALF);
         localparam logic [CW-1:0] LAST = CW'(2 * HALF - 1);
         localparam logic [CW-1:0] MID  = CW'(HALF);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !run)  cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign bit_o = (cnt < MID) ? START_BIT : ~START_BIT;
      end
   endgenerate
endmodule

// File: rtl/lane_pattern_gen.sv
module lane_pattern_gen
   import lpg_pkg::*;
#(
   parameter int CTRL_W    = 8,
   parameter int PRBS_LEN  = 7,
   parameter int PRBS_TAP  = 6,
   parameter int LF_HALF   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              data_in,
   input  logic              data_valid_in,
   output logic              ser_out,
   output logic              ser_valid,
   output logic [MODE_W-1:0] mode_o,
   output logic              illegal_seen
);
   generate
      if (CTRL_W <= MODE_W) begin : g_bad_ctrl
         $error("lane_pattern_gen: CTRL_W must exceed the mode field width");
      end
   endgenerate

   lpg_mode_e mode;
   logic      prbs_bit, lf_bit, hf_bit;
   logic      unused_ctrl_hi;

   // Upper control bits belong to neighbouring fields
   assign unused_ctrl_hi = ^ctrl_wdata[CTRL_W-1:MODE_W];

   lpg_mode_ctrl u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ctrl_wr),
      .wr_mode   (ctrl_wdata[MODE_W-1:0]),
      .mode_q    (mode),
      .illegal_q (illegal_seen)
   );

   lpg_prbs #(.LEN(PRBS_LEN), .TAP(PRBS_TAP), .SEED('1)) u_prbs (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (mode == MODE_PRBS),
      .bit_o (prbs_bit)
   );

   lpg_toggle #(.HALF(LF_HALF), .START_BIT(1'b0)) u_lowtog (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (mode == MODE_LOWTOG),
      .bit_o (lf_bit)
   );

   lpg_toggle #(.HALF(1), .START_BIT(1'b1)) u_hightog (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (mode == MODE_HIGHTOG),
      .bit_o (hf_bit)
   );

   // Shared output stage: one cycle of latency for every source
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ser_out   <= 1'b0;
         ser_valid <= 1'b0;
      end else begin
         unique case (mode)
            MODE_NORMAL:  begin ser_out <= data_in;  ser_valid <= data_valid_in; end
            MODE_PRBS:    begin ser_out <= prbs_bit; ser_valid <= 1'b1; end
            MODE_LOWTOG:  begin ser_out <= lf_bit;   ser_valid <= 1'b1; end
            MODE_HIGHTOG: begin ser_out <= hf_bit;   ser_valid <= 1'b1; end
            default:      begin ser_out <= 1'b0;     ser_valid <= 1'b0; end
         endcase
      end
   end

   assign mode_o = mode;
endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
   parameter int CTRL_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctrl_wr,
   input logic [CTRL_W-1:0] ctrl_wdata,
   input logic              data_in,
   input logic              data_valid_in,
   input logic              ser_out,
   input logic              ser_valid,
   input logic [1:0]        mode_o,
   input logic              illegal_seen
);
   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |=> (mode_o == 2'd0 && !illegal_seen && !ser_out && !ser_valid)); // R8

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(mode_o)); // R1

   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd0) |=> (ser_out == $past(data_in) && ser_valid == $past(data_valid_in))); // R2

   AST_PATTERN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 2'd0) |=> ser_valid); // R4

   AST_FAST_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd3 && $past(mode_o) == 2'd3) |=> (ser_out != $past(ser_out))); // R6

   AST_NO_FAST_TO_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && ctrl_wdata[1:0] == 2'd2 && mode_o == 2'd3) |=> (mode_o == 2'd3 && illegal_seen)); // R7

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_seen |=> illegal_seen); // R7
endmodule

bind lane_pattern_gen lpg_checker #(.CTRL_W(CTRL_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .ctrl_wr       (ctrl_wr),
   .ctrl_wdata    (ctrl_wdata),
   .data_in       (data_in),
   .data_valid_in (data_valid_in),
   .ser_out       (ser_out),
   .ser_valid     (ser_valid),
   .mode_o        (mode_o),
   .illegal_seen  (illegal_seen)
);

// File: tb/lane_pattern_gen_tb.sv
`timescale 1ns/1ps
module lane_pattern_gen_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctrl_wr = 1'b0;
   logic [7:0] ctrl_wdata = 8'h00;
   logic       data_in = 1'b0;
   logic       data_valid_in = 1'b0;
   logic       ser_out, ser_valid, illegal_seen;
   logic [1:0] mode_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lane_pattern_gen dut_i (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .data_in(data_in), .data_valid_in(data_valid_in), .ser_out(ser_out),
      .ser_valid(ser_valid), .mode_o(mode_o), .illegal_seen(illegal_seen)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Called at a negedge; returns at the next negedge, after the write edge
   task automatic wr_mode(input logic [7:0] v);
      ctrl_wr = 1'b1; ctrl_wdata = v;
      @(negedge clk);
      ctrl_wr = 1'b0; ctrl_wdata = 8'h00;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R8", "mode after reset", mode_o, 0);
      check("R8", "flag after reset", illegal_seen, 0);
      check("R8", "out after reset", ser_out, 0);
      check("R8", "valid after reset", ser_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_passthru();
      int bad = 0;
      logic d_prev = 1'b0, v_prev = 1'b0;
      for (int i = 0; i < 24; i++) begin
         data_in = ((i * 7) % 5) > 1;
         data_valid_in = (i % 3) != 0;
         d_prev = data_in; v_prev = data_valid_in;
         @(negedge clk);
         if (ser_out !== d_prev || ser_valid !== v_prev) bad++;
      end
      check("R2", "pass-through mismatches", bad, 0);
      data_valid_in = 1'b0;
   endtask

   task automatic t_prbs();
      logic b [0:253];
      logic r [0:13];
      int ones = 0, rec_bad = 0, per_bad = 0, val_bad = 0, re_bad = 0;
      data_valid_in = 1'b0;
      wr_mode(8'h01);
      check("R1", "mode after write 1", mode_o, 1);
      for (int i = 0; i < 254; i++) begin
         @(negedge clk);
         b[i] = ser_out;
         if (ser_valid !== 1'b1) val_bad++;
      end
      for (int i = 0; i < 7; i++) if (b[i] === 1'b1) ones++;
      check("R3", "seed ones at start", ones, 7);
      for (int n = 0; n + 7 < 254; n++) if (b[n+7] !== (b[n] ^ b[n+1])) rec_bad++;
      check("R3", "recurrence mismatches", rec_bad, 0);
      for (int i = 0; i < 127; i++) if (b[i+127] !== b[i]) per_bad++;
      check("R3", "period-127 mismatches", per_bad, 0);
      check("R4", "valid low in PRBS mode", val_bad, 0);
      wr_mode(8'h00);
      wr_mode(8'h01);
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         r[i] = ser_out;
         if (r[i] !== b[i]) re_bad++;
      end
      check("R3", "restart on re-entry mismatches", re_bad, 0);
      wr_mode(8'h00);
   endtask

   task automatic t_lowtog_rewrite();
      int bad = 0;
      int idx;
      wr_mode(8'h02);
      check("R1", "mode after write 2", mode_o, 2);
      for (idx = 0; idx < 3; idx++) begin
         @(negedge clk);
         if (ser_out !== ((idx % 10) >= 5) || ser_valid !== 1'b1) bad++;
      end
      // idx = 3: rewrite the same mode; the write-edge output is bit 3
      wr_mode(8'h02);
      if (ser_out !== 1'b0) bad++;
      for (idx = 4; idx < 34; idx++) begin
         @(negedge clk);
         if (ser_out !== ((idx % 10) >= 5) || ser_valid !== 1'b1) bad++;
      end
      check("R9", "slow toggle after same-mode rewrite mismatches", bad, 0);
      wr_mode(8'h00);
   endtask

   task automatic t_lowtog_shape();
      int bad = 0;
      data_valid_in = 1'b0;
      wr_mode(8'h02);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (ser_out !== ((i % 10) >= 5)) bad++;
      end
      check("R5", "slow toggle 0000011111 mismatches", bad, 0);
      check("R4", "valid in slow toggle", ser_valid, 1);
      wr_mode(8'h00);
   endtask

   task automatic t_hightog_illegal();
      int bad = 0;
      logic prev;
      wr_mode(8'h03);
      @(negedge clk);
      check("R6", "fast toggle first bit", ser_out, 1);
      prev = ser_out;
      for (int i = 0; i < 9; i++) begin
         @(negedge clk);
         if (ser_out === prev) bad++;
         prev = ser_out;
      end
      check("R6", "fast toggle alternation errors", bad, 0);
      wr_mode(8'h02);
      if (ser_out === prev) bad++;
      prev = ser_out;
      check("R7", "mode after refused write", mode_o, 3);
      check("R7", "flag after refused write", illegal_seen, 1);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (ser_out === prev) bad++;
         prev = ser_out;
      end
      check("R7", "fast toggle continuity after refusal", bad, 0);
      wr_mode(8'h00);
      check("R7", "flag sticky in mode 0", illegal_seen, 1);
      wr_mode(8'h02);
      check("R7", "mode 2 via mode 0", mode_o, 2);
      @(negedge clk);
      check("R5", "slow toggle first bit after guard", ser_out, 0);
      wr_mode(8'h00);
   endtask

   task automatic t_reserved_bits();
      wr_mode(8'hFC);
      check("R1", "upper bits ignored, mode 0", mode_o, 0);
      wr_mode(8'hAB);
      check("R1", "upper bits ignored, mode 3", mode_o, 3);
      repeat (4) @(negedge clk);
      check("R1", "mode holds without write", mode_o, 3);
      wr_mode(8'h00);
   endtask

   task automatic t_reset_mid();
      int bad = 0;
      wr_mode(8'h02);
      repeat (7) @(negedge clk);
      do_reset();
      wr_mode(8'h02);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (ser_out !== (i >= 5)) bad++;
      end
      check("R8", "slow toggle restart after reset", bad, 0);
      wr_mode(8'h00);
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      t_passthru();
      t_prbs();
      t_lowtog_shape();
      t_lowtog_rewrite();
      t_hightog_illegal();
      do_reset();
      t_reserved_bits();
      t_reset_mid();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule